// File: doc/BRIEF.md
# Device-to-Host Status Frame Writer

This block produces the status frames that a storage host adapter port deposits into the host's received-frame area. It also raises the port interrupt causes that go with each frame. Three kinds of frame are supported. The first is a 20-byte register frame that answers a command. The second is the initial register frame sent after a port reset, which carries a fixed signature. The third is an 8-byte set-bits frame that reports completed queued commands through a sticky bitmap.

Each frame goes out as a stream of byte writes, one byte per clock, with an offset relative to the base of the receive area. The register frames start at offset 0x40 and the set-bits frame starts at offset 0x58. Only one frame is in flight at a time. While a frame is in flight, `ready` is low and new requests are not taken.

A queued-command completion always pulses the active-clear line for its tag. On failure it also pulses the error-set line for its tag. These pulses happen even when frame reception is disabled. In that case no frame is written and no cause is raised.

Top module: `fis_resp_writer`

## Requirements
- R1: After reset, `ready` is 1, and `wr_valid`, the three cause outputs, `act_clr` and `err_set` are all 0.
- R2: A request taken while `rx_en` or `area_ok` is 0 produces no byte writes and no cause pulse. It is still consumed, and `ready` stays 1.
- R3: Register frame emission starts in the cycle after the request is taken. It writes one byte per cycle at offsets 0x40 to 0x53. Byte 0 is 0x34. Byte 1 is 0x40 if `glob_pend` was 1 when the request was taken, and 0x00 otherwise. Byte 2 is `st_in` and byte 3 is `er_in`.
- R4: In a register frame, byte k (k = 4 to 13) equals `cmd_bytes[8*(k-4) +: 8]`, and bytes 14 to 19 are 0x00.
- R5: `cause_d2h` pulses together with the last byte of a register or initial frame. `cause_tfe` pulses with it only when bit 0 of the status byte is 1.
- R6: The initial frame has the same layout as a register frame, with these command bytes: byte 4 = 0x01 and byte 12 = 0x01. When `is_packet` is 1, byte 5 = 0x14 and byte 6 = 0xEB. All other command bytes are 0x00.
- R7: The set-bits frame is 8 bytes at offsets 0x58 to 0x5F. Byte 0 is the error value, byte 1 is 0x00, byte 2 is the status value ANDed with 0x77, and byte 3 is 0x00. Bytes 4 to 7 hold the completion bitmap, least significant byte first. `cause_sdb` pulses with the last byte.
- R8: A failed completion reports status 0x41 and error 0x04. A successful completion reports status 0x50 and error `er_in`.
- R9: Each written set-bits frame ORs bit `cmpl_tag` into the sticky bitmap. A `done_clr` pulse empties the bitmap. A completion taken while reception is disabled leaves the bitmap unchanged.
- R10: One cycle after a completion is taken, `act_clr` is the one-hot mask of `cmpl_tag`. `err_set` carries the same mask when `cmpl_fail` is 1, and 0 otherwise.
- R11: `ready` is 0 from the edge that takes a request until the last byte has been written. Simultaneous requests are served in the order initial, register, set-bits. Lower-priority requests presented in the same cycle are dropped, so a dropped completion gives no `act_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Frame reception enabled |
| area_ok | input | 1 | Receive area configured |
| glob_pend | input | 1 | Global interrupt status nonzero |
| is_packet | input | 1 | Attached device is a packet device |
| st_in | input | 8 | Device status byte |
| er_in | input | 8 | Device error byte |
| cmd_bytes | input | 80 | Command frame bytes 4..13, byte 4 in bits 7:0 |
| req_init | input | 1 | Request the initial frame |
| req_reg | input | 1 | Request a register frame |
| req_sdb | input | 1 | Request a completion (set-bits) frame |
| cmpl_tag | input | TAG_W | Completed tag index |
| cmpl_fail | input | 1 | Completion ended in error |
| done_clr | input | 1 | Empty the sticky completion bitmap |
| ready | output | 1 | Writer idle, request can be taken |
| wr_valid | output | 1 | Byte write valid |
| wr_off | output | OFF_W | Byte offset in receive area |
| wr_data | output | 8 | Byte value |
| cause_d2h | output | 1 | Register-frame interrupt cause pulse |
| cause_tfe | output | 1 | Task-file-error cause pulse |
| cause_sdb | output | 1 | Set-bits cause pulse |
| act_clr | output | TAGS | Active-tag clear pulse |
| err_set | output | TAGS | Error-tag set pulse |

## Verification
A request is taken at a rising edge. Byte i of the frame appears on the write port i cycles after that edge, and the cause pulses sit on the same cycle as the final byte. `act_clr` and `err_set` are valid only during the cycle right after the taking edge. The driver computes every expected byte with its offset and cause flags and queues it before it raises the request. The monitor samples on falling edges: each cycle with `wr_valid` high pops one queued item and compares it. Completion pulses are checked by the driver on the first falling edge after the request, and any write arriving while the queue is empty is reported as an error.

// File: rtl/fis_pkg.sv
package fis_pkg;

   localparam int FRAME_MAX = 20;
   localparam int REG_LEN   = 20;
   localparam int SDB_LEN   = 8;
   localparam int LEN_W     = 5;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_INIT = 2'd1,
      K_REG  = 2'd2,
      K_SDB  = 2'd3
   } fkind_e;

   typedef struct packed {
      logic [FRAME_MAX-1:0][7:0] bytes;
      logic [LEN_W-1:0]          len;
      logic                      c_d2h;
      logic                      c_tfe;
      logic                      c_sdb;
   } frame_t;

   localparam logic [7:0] REG_TYPE   = 8'h34;
   localparam logic [7:0] SDB_MASK   = 8'h77;
   localparam logic [7:0] ST_FAIL    = 8'h41;
   localparam logic [7:0] ST_OK      = 8'h50;
   localparam logic [7:0] ER_ABORT   = 8'h04;
   localparam logic [7:0] SIG_PKT_LO = 8'h14;
   localparam logic [7:0] SIG_PKT_HI = 8'hEB;

endpackage

// File: rtl/fis_frame_fmt.sv
module fis_frame_fmt
   import fis_pkg::*;
#(
   parameter int TAGS = 32
)(
   input  fkind_e            kind,
   input  logic [7:0]        st_in,
   input  logic [7:0]        er_in,
   input  logic [79:0]       cmd_bytes,
   input  logic              glob_pend,
   input  logic              is_packet,
   input  logic              cmpl_fail,
   input  logic [TAGS-1:0]   map_next,
   output frame_t            frame
);
   logic [31:0] map32;
   logic [7:0]  sdb_st;
   logic [7:0]  sdb_er;

   generate
      if (TAGS == 32) begin : g_full
         assign map32 = map_next;
      end else begin : g_pad
         assign map32 = {{(32-TAGS){1'b0}}, map_next};
      end
   endgenerate

   assign sdb_st = (cmpl_fail ? ST_FAIL : ST_OK) & SDB_MASK;
   assign sdb_er = cmpl_fail ? ER_ABORT : er_in;

   always_comb begin
      frame = '0;
      if (kind == K_SDB) begin
         frame.bytes[0] = sdb_er;
         frame.bytes[2] = sdb_st;
         for (int b = 0; b < 4; b++) begin
            frame.bytes[4+b] = map32[8*b +: 8];
         end
         frame.len   = LEN_W'(SDB_LEN);
         frame.c_sdb = 1'b1;
      end else begin
         frame.bytes[0] = REG_TYPE;
         frame.bytes[1] = glob_pend ? 8'h40 : 8'h00;
         frame.bytes[2] = st_in;
         frame.bytes[3] = er_in;
         if (kind == K_INIT) begin
            frame.bytes[4]  = 8'h01;
            frame.bytes[12] = 8'h01;
            if (is_packet) begin
               frame.bytes[5] = SIG_PKT_LO;
               frame.bytes[6] = SIG_PKT_HI;
            end
         end else begin
            for (int k = 0; k < 10; k++) begin
               frame.bytes[4+k] = cmd_bytes[8*k +: 8];
            end
         end
         frame.len   = LEN_W'(REG_LEN);
         frame.c_d2h = 1'b1;
         frame.c_tfe = st_in[0];
      end
   end

endmodule

// File: rtl/fis_done_map.sv
module fis_done_map #(
   parameter int TAGS  = 32,
   parameter int TAG_W = $clog2(TAGS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              store,
   input  logic [TAG_W-1:0]  tag,
   input  logic              fail,
   input  logic              clr,
   output logic [TAGS-1:0]   map_next,
   output logic [TAGS-1:0]   act_clr,
   output logic [TAGS-1:0]   err_set
);
   logic [TAGS-1:0] map_q;
   logic [TAGS-1:0] tag_hot;

   assign tag_hot  = TAGS'(1) << tag;
   assign map_next = (clr ? '0 : map_q) | tag_hot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q   <= '0;
         act_clr <= '0;
         err_set <= '0;
      end else begin
         act_clr <= take ? tag_hot : '0;
         err_set <= (take && fail) ? tag_hot : '0;
         if (take && store) begin
            map_q <= map_next;
         end else if (clr) begin
            map_q <= '0;
         end
      end
   end

   // R10
   act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_clr));

   // R10
   err_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set & ~act_clr) == '0);

endmodule

// File: rtl/fis_byte_emit.sv
module fis_byte_emit
   import fis_pkg::*;
#(
   parameter int OFF_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  frame_t            frame,
   input  logic [OFF_W-1:0]  base,
   output logic              busy,
   output logic              wr_valid,
   output logic [OFF_W-1:0]  wr_off,
   output logic [7:0]        wr_data,
   output logic              cause_d2h,
   output logic              cause_tfe,
   output logic              cause_sdb
);
   frame_t            frm_q;
   logic [OFF_W-1:0]  base_q;
   logic [LEN_W-1:0]  idx_q;
   logic              act_q;
   logic              last;

   assign last = (idx_q == frm_q.len - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_q  <= '0;
         base_q <= '0;
         idx_q  <= '0;
         act_q  <= 1'b0;
      end else if (load && !act_q) begin
         frm_q  <= frame;
         base_q <= base;
         idx_q  <= '0;
         act_q  <= 1'b1;
      end else if (act_q) begin
         if (last) begin
            act_q <= 1'b0;
         end else begin
            idx_q <= idx_q + LEN_W'(1);
         end
      end
   end

   assign busy      = act_q;
   assign wr_valid  = act_q;
   assign wr_off    = base_q + OFF_W'(idx_q);
   assign wr_data   = frm_q.bytes[idx_q];
   assign cause_d2h = act_q && last && frm_q.c_d2h;
   assign cause_tfe = act_q && last && frm_q.c_tfe;
   assign cause_sdb = act_q && last && frm_q.c_sdb;

   // R3
   off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !last) |=> (wr_valid && wr_off == $past(wr_off) + OFF_W'(1)));

   // R5
   tfe_with_d2h_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_tfe |-> cause_d2h);

   // R5
   cause_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cause_d2h, cause_sdb}) <= 1);

endmodule

// File: rtl/fis_resp_writer.sv
module fis_resp_writer
   import fis_pkg::*;
#(
   parameter int TAGS    = 32,
   parameter int TAG_W   = $clog2(TAGS),
   parameter int OFF_W   = 8,
   parameter int REG_OFF = 'h40,
   parameter int SDB_OFF = 'h58
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              area_ok,
   input  logic              glob_pend,
   input  logic              is_packet,
   input  logic [7:0]        st_in,
   input  logic [7:0]        er_in,
   input  logic [79:0]       cmd_bytes,
   input  logic              req_init,
   input  logic              req_reg,
   input  logic              req_sdb,
   input  logic [TAG_W-1:0]  cmpl_tag,
   input  logic              cmpl_fail,
   input  logic              done_clr,
   output logic              ready,
   output logic              wr_valid,
   output logic [OFF_W-1:0]  wr_off,
   output logic [7:0]        wr_data,
   output logic              cause_d2h,
   output logic              cause_tfe,
   output logic              cause_sdb,
   output logic [TAGS-1:0]   act_clr,
   output logic [TAGS-1:0]   err_set
);
   localparam int REG_END = REG_OFF + REG_LEN;
   localparam int SDB_END = SDB_OFF + SDB_LEN;

   if (TAGS < 2 || TAGS > 32) begin : g_bad_tags
      $error("TAGS must lie in 2..32");
   end
   if (REG_END > (1 << OFF_W) || SDB_END > (1 << OFF_W)) begin : g_bad_off
      $error("frame offsets exceed OFF_W");
   end

   fkind_e            kind;
   logic              gate;
   logic              busy;
   logic              load;
   frame_t            frame;
   logic [TAGS-1:0]   map_next;
   logic [OFF_W-1:0]  base;

   always_comb begin
      kind = K_NONE;
      if (!busy) begin
         if (req_init)     kind = K_INIT;
         else if (req_reg) kind = K_REG;
         else if (req_sdb) kind = K_SDB;
      end
   end

   assign gate  = rx_en && area_ok;
   assign load  = (kind != K_NONE) && gate;
   assign base  = (kind == K_SDB) ? OFF_W'(SDB_OFF) : OFF_W'(REG_OFF);
   assign ready = !busy;

   fis_frame_fmt #(.TAGS(TAGS)) u_fmt (
      .kind      (kind),
      .st_in     (st_in),
      .er_in     (er_in),
      .cmd_bytes (cmd_bytes),
      .glob_pend (glob_pend),
      .is_packet (is_packet),
      .cmpl_fail (cmpl_fail),
      .map_next  (map_next),
      .frame     (frame)
   );

   fis_done_map #(.TAGS(TAGS), .TAG_W(TAG_W)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (kind == K_SDB),
      .store    (gate),
      .tag      (cmpl_tag),
      .fail     (cmpl_fail),
      .clr      (done_clr),
      .map_next (map_next),
      .act_clr  (act_clr),
      .err_set  (err_set)
   );

   fis_byte_emit #(.OFF_W(OFF_W)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .frame     (frame),
      .base      (base),
      .busy      (busy),
      .wr_valid  (wr_valid),
      .wr_off    (wr_off),
      .wr_data   (wr_data),
      .cause_d2h (cause_d2h),
      .cause_tfe (cause_tfe),
      .cause_sdb (cause_sdb)
   );

   // R2
   gated_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && (req_init || req_reg || req_sdb) && !gate) |=> (ready && !wr_valid));

   // R11
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !ready);

   // R3
   first_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> (wr_off == OFF_W'(REG_OFF) || wr_off == OFF_W'(SDB_OFF)));

endmodule

// File: tb/fis_resp_writer_bench.sv
module fis_resp_writer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int TAGS = 32;
   localparam int TAG_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0, area_ok = 1'b0, glob_pend = 1'b0, is_packet = 1'b0;
   logic [7:0] st_in = '0, er_in = '0;
   logic [79:0] cmd_bytes = '0;
   logic req_init = 1'b0, req_reg = 1'b0, req_sdb = 1'b0;
   logic [TAG_W-1:0] cmpl_tag = '0;
   logic cmpl_fail = 1'b0, done_clr = 1'b0;
   logic ready, wr_valid, cause_d2h, cause_tfe, cause_sdb;
   logic [7:0] wr_off, wr_data;
   logic [TAGS-1:0] act_clr, err_set;

   always #(CLK_PERIOD/2) clk = ~clk;

   fis_resp_writer u_fis_resp_writer (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .area_ok(area_ok),
      .glob_pend(glob_pend), .is_packet(is_packet), .st_in(st_in),
      .er_in(er_in), .cmd_bytes(cmd_bytes), .req_init(req_init),
      .req_reg(req_reg), .req_sdb(req_sdb), .cmpl_tag(cmpl_tag),
      .cmpl_fail(cmpl_fail), .done_clr(done_clr), .ready(ready),
      .wr_valid(wr_valid), .wr_off(wr_off), .wr_data(wr_data),
      .cause_d2h(cause_d2h), .cause_tfe(cause_tfe), .cause_sdb(cause_sdb),
      .act_clr(act_clr), .err_set(err_set)
   );

   typedef struct packed {
      logic [7:0] off;
      logic [7:0] data;
      logic [2:0] cz;   // {d2h, tfe, sdb}
      logic [7:0] req;  // requirement number
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   logic [31:0] exp_map = '0;
   logic finished = 1'b0;

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // monitor: pops one queued byte per write cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (exp_q.size() == 0) begin
               chk("R2 unexpected write", {wr_off, wr_data}, 64'hdead);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               chk($sformatf("R%0d offset", e.req), wr_off, e.off);
               chk($sformatf("R%0d data@%h", e.req, e.off), wr_data, e.data);
               chk("R5/R7 causes", {cause_d2h, cause_tfe, cause_sdb}, e.cz);
            end
         end else if (cause_d2h || cause_tfe || cause_sdb) begin
            chk("R5 cause without write", {cause_d2h, cause_tfe, cause_sdb}, 0);
         end
      end
   end

   task automatic push_reg(input bit init, input bit pkt);
      logic [7:0] b [20];
      for (int i = 0; i < 20; i++) b[i] = 8'h00;
      b[0] = 8'h34;
      b[1] = glob_pend ? 8'h40 : 8'h00;
      b[2] = st_in;
      b[3] = er_in;
      if (init) begin
         b[4] = 8'h01; b[12] = 8'h01;
         if (pkt) begin b[5] = 8'h14; b[6] = 8'hEB; end
      end else begin
         for (int k = 4; k < 14; k++) b[k] = cmd_bytes[8*(k-4) +: 8];
      end
      for (int i = 0; i < 20; i++) begin
         item_t e;
         e.off  = 8'h40 + 8'(i);
         e.data = b[i];
         e.cz   = (i == 19) ? {1'b1, st_in[0], 1'b0} : 3'b000;
         e.req  = init ? 8'd6 : ((i < 4) ? 8'd3 : 8'd4);
         exp_q.push_back(e);
      end
   endtask

   task automatic push_sdb(input logic [31:0] map, input bit fail);
      logic [7:0] b [8];
      b[0] = fail ? 8'h04 : er_in;
      b[1] = 8'h00;
      b[2] = (fail ? 8'h41 : 8'h50) & 8'h77;
      b[3] = 8'h00;
      for (int k = 0; k < 4; k++) b[4+k] = map[8*k +: 8];
      for (int i = 0; i < 8; i++) begin
         item_t e;
         e.off  = 8'h58 + 8'(i);
         e.data = b[i];
         e.cz   = (i == 7) ? 3'b001 : 3'b000;
         e.req  = (i < 4) ? 8'd8 : 8'd9;
         exp_q.push_back(e);
      end
   endtask

   task automatic wait_idle();
      while (!ready || exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic do_reg(input bit init);
      if (rx_en && area_ok) push_reg(init, is_packet);
      @(negedge clk);
      req_init = init; req_reg = !init;
      @(negedge clk);
      req_init = 0; req_reg = 0;
      if (rx_en && area_ok) chk("R11 ready low while busy", ready, 0);
      else chk("R2 ready stays high", ready, 1);
      wait_idle();
   endtask

   task automatic do_sdb(input logic [4:0] tag, input bit fail);
      logic [31:0] m;
      bit en;
      en = rx_en && area_ok;
      m = exp_map | (32'h1 << tag);
      if (en) begin
         exp_map = m;
         push_sdb(m, fail);
      end
      @(negedge clk);
      req_sdb = 1; cmpl_tag = tag; cmpl_fail = fail;
      @(negedge clk);
      req_sdb = 0;
      chk("R10 act_clr", act_clr, 32'h1 << tag);
      chk("R10 err_set", err_set, fail ? (32'h1 << tag) : 32'h0);
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ready", ready, 1);
      chk("R1 outputs", {wr_valid, cause_d2h, cause_tfe, cause_sdb}, 0);
      chk("R1 pulses", {act_clr, err_set}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 ready after release", ready, 1);

      rx_en = 1; area_ok = 1;
      st_in = 8'h50; er_in = 8'h01;
      // R6 initial frames, disk then packet device
      do_reg(1'b1);
      is_packet = 1; st_in = 8'h51;
      do_reg(1'b1);
      is_packet = 0;

      // R3 R4 R5 register frames
      cmd_bytes = 80'hA1B2_C3D4_E5F6_0718_293A;
      st_in = 8'h50; er_in = 8'h00; glob_pend = 0;
      do_reg(1'b0);
      cmd_bytes = 80'h0F1E_2D3C_4B5A_6978_8796;
      st_in = 8'h51; er_in = 8'h04; glob_pend = 1;
      do_reg(1'b0);
      glob_pend = 0;

      // R7 R8 R9 R10 completions accumulating
      er_in = 8'h00;
      do_sdb(5'd3, 1'b0);
      do_sdb(5'd7, 1'b1);
      do_sdb(5'd31, 1'b0);

      // R9 clear then new completion
      @(negedge clk); done_clr = 1;
      @(negedge clk); done_clr = 0;
      exp_map = '0;
      do_sdb(5'd0, 1'b0);

      // R2 gating: disabled reception
      rx_en = 0;
      do_reg(1'b0);
      do_sdb(5'd5, 1'b1);
      rx_en = 1; area_ok = 0;
      do_sdb(5'd6, 1'b0);
      do_reg(1'b1);
      area_ok = 1;
      // R9 map unchanged by gated completions
      do_sdb(5'd1, 1'b0);

      // R11 priority: register over completion, completion dropped
      cmd_bytes = 80'h1122_3344_5566_7788_99AA;
      st_in = 8'h50;
      push_reg(1'b0, 1'b0);
      @(negedge clk);
      req_reg = 1; req_sdb = 1; cmpl_tag = 5'd9;
      @(negedge clk);
      req_reg = 0; req_sdb = 0;
      chk("R11 dropped completion", act_clr, 0);
      wait_idle();
      // R11 initial over register
      is_packet = 1;
      push_reg(1'b1, 1'b1);
      @(negedge clk);
      req_init = 1; req_reg = 1;
      @(negedge clk);
      req_init = 0; req_reg = 0;
      // R11 request during busy ignored
      req_sdb = 1; cmpl_tag = 5'd12;
      @(negedge clk);
      req_sdb = 0;
      chk("R11 busy request ignored", act_clr, 0);
      wait_idle();
      repeat (3) @(negedge clk);
      chk("R11 queue drained", exp_q.size(), 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule